// File: doc/BRIEF.md
# x86 Prefix and Opcode Front-End

This block sits at the head of an x86 instruction decoder. It takes instruction bytes one at a time over a valid/ready handshake. It absorbs any run of prefix bytes and accumulates their effect into per-instruction context: operand size, address size, repeat kind and segment override. It recognises the two-byte escape code and then produces a single decoded-opcode record for the instruction. ModR/M parsing, operand fetch and execution belong to later stages.

A size prefix does not toggle the size on each occurrence. It selects the size opposite to the default given by the mode input, so a second copy changes nothing. Repeat and segment prefixes overwrite one another, and the last one seen wins. The record carries the opcode byte, an escape flag, the effective operand and address sizes, the repeat kind, the segment and whether it came from an override, and the number of bytes consumed. An instruction whose prefix run would leave no room for an opcode within the length limit is dropped and flagged.

The controller has four states. ST_PREFIX scans bytes and has ready high. ST_ESCAPE waits for the byte that follows the escape code, with ready high. ST_EMIT presents the record for one cycle, with ready low. ST_FAULT presents the error for one cycle, with ready low.

The transitions are:
- T_PFX: a prefix is accepted in ST_PREFIX, and the block stays in ST_PREFIX.
- T_ESC: the escape code is accepted, moving ST_PREFIX to ST_ESCAPE.
- T_OPC: an opcode is accepted, moving ST_PREFIX to ST_EMIT.
- T_ESC2: any byte is accepted in ST_ESCAPE, moving to ST_EMIT.
- T_OVF: a prefix or escape byte fills the last allowed slot, moving ST_PREFIX to ST_FAULT.
- T_EMIT: ST_EMIT returns to ST_PREFIX and clears the context.
- T_DROP: ST_FAULT returns to ST_PREFIX and clears the context.

Top module: `opc_frontend`

## Requirements
- R1: After reset, byte_ready_o is 1 and both rec_valid_o and err_o are 0.
- R2: If byte 0x66 appears among the prefixes, rec_op32_o is the inverse of mode32_i. Otherwise rec_op32_o equals mode32_i. Several 0x66 bytes act the same as one.
- R3: Byte 0x67 affects rec_ad32_o in the same way that 0x66 affects rec_op32_o, and is also insensitive to repetition.
- R4: rec_rep_o reports the repeat kind. 0 means no repeat prefix, 1 means byte 0xF2 (repeat while not equal) and 2 means byte 0xF3 (repeat while equal). When both appear, the later one decides.
- R5: Bytes 0x26, 0x2E, 0x36 and 0x3E set rec_seg_o to 0 (ES), 1 (CS), 2 (SS) and 3 (DS), with rec_seg_ovr_o = 1, and the later override wins. Without an override, rec_seg_o = 3 and rec_seg_ovr_o = 0.
- R6: The first byte that is neither a prefix nor 0x0F is the opcode. The cycle after it is accepted, rec_valid_o is 1 for exactly one cycle, byte_ready_o is 0 in that cycle, and rec_opcode_o holds the byte.
- R7: After byte 0x0F, the next byte is taken as the opcode whatever its value, and rec_escape_o = 1.
- R8: rec_len_o equals the total count of prefix, escape and opcode bytes accepted for the instruction.
- R9: An instruction may have at most MAX_LEN (15) bytes. If the MAX_LEN-th byte is a prefix or 0x0F, err_o is 1 for one cycle in the next cycle, no record is produced, and the instruction is discarded.
- R10: After a record or an error, all accumulated context is cleared, so the next instruction starts from defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32_i | input | 1 | Default size mode: 0 = 16-bit, 1 = 32-bit |
| byte_valid_i | input | 1 | Instruction byte present |
| byte_data_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| rec_valid_o | output | 1 | Decoded-opcode record valid (one cycle) |
| rec_opcode_o | output | 8 | Opcode byte |
| rec_escape_o | output | 1 | Opcode came from the secondary space |
| rec_op32_o | output | 1 | Effective operand size is 32 bits |
| rec_ad32_o | output | 1 | Effective address size is 32 bits |
| rec_rep_o | output | 2 | Repeat kind (0 none, 1 not-equal, 2 equal) |
| rec_seg_o | output | 2 | Segment (0 ES, 1 CS, 2 SS, 3 DS) |
| rec_seg_ovr_o | output | 1 | Segment came from an override prefix |
| rec_len_o | output | $clog2(MAX_LEN+1) | Bytes consumed by the instruction |
| err_o | output | 1 | Over-length instruction dropped (one cycle) |

## Verification
The properties assume that mode32_i is stable while an instruction is being scanned. They also assume that byte_data_i has a known value whenever byte_valid_i is high. The bench changes the mode only between instructions, while the block is idle in ST_PREFIX. It drives and releases bytes on the falling clock edge, so every accepted byte is a defined value. The bench waits for byte_ready_o before it offers each byte, so the record and error cycles never overlap an attempted transfer.

// File: rtl/opc_fe_pkg.sv
package opc_fe_pkg;

    localparam logic [7:0] CODE_OPSZ  = 8'h66;
    localparam logic [7:0] CODE_ADSZ  = 8'h67;
    localparam logic [7:0] CODE_REPNE = 8'hF2;
    localparam logic [7:0] CODE_REPE  = 8'hF3;
    localparam logic [7:0] CODE_ESC   = 8'h0F;

    typedef enum logic [2:0] {
        BK_OPC,
        BK_OPSZ,
        BK_ADSZ,
        BK_REP,
        BK_SEG,
        BK_ESC
    } byte_kind_e;

    typedef enum logic [1:0] {
        REP_NONE = 2'd0,
        REP_NE   = 2'd1,
        REP_EQ   = 2'd2
    } rep_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_PREFIX,
        ST_ESCAPE,
        ST_EMIT,
        ST_FAULT
    } fe_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       esc;
        logic       op32;
        logic       ad32;
        rep_e       rep;
        seg_e       seg;
        logic       ovr;
    } rec_t;

    localparam rec_t REC_IDLE = '{
        opcode: 8'h00,
        esc:    1'b0,
        op32:   1'b0,
        ad32:   1'b0,
        rep:    REP_NONE,
        seg:    SEG_DS,
        ovr:    1'b0
    };

endpackage

// File: rtl/opc_fe_classify.sv
module opc_fe_classify
    import opc_fe_pkg::*;
(
    input  logic [7:0] code_i,
    output byte_kind_e kind_o,
    output rep_e       rep_sel_o,
    output seg_e       seg_sel_o
);

    logic is_seg;

    // Segment overrides share the pattern 001ss110; ss picks the segment.
    assign is_seg    = (code_i[7:5] == 3'b001) && (code_i[2:0] == 3'b110);
    assign seg_sel_o = seg_e'(code_i[4:3]);
    assign rep_sel_o = code_i[0] ? REP_EQ : REP_NE;

    always_comb begin
        if (is_seg) begin
            kind_o = BK_SEG;
        end else begin
            unique case (code_i)
                CODE_OPSZ:             kind_o = BK_OPSZ;
                CODE_ADSZ:             kind_o = BK_ADSZ;
                CODE_REPNE, CODE_REPE: kind_o = BK_REP;
                CODE_ESC:              kind_o = BK_ESC;
                default:               kind_o = BK_OPC;
            endcase
        end
    end

endmodule

// File: rtl/opc_fe_lencnt.sv
module opc_fe_lencnt #(
    parameter int MAX_LEN = 15,
    parameter int CW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [CW-1:0] count_o,
    output logic          last_slot_o
);

    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_LEN - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o     = count_q;
    // The byte being offered now would be the final one allowed.
    assign last_slot_o = (count_q == LAST_IDX);

endmodule

// File: rtl/opc_fe_ctx.sv
module opc_fe_ctx
    import opc_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       take_pfx_i,
    input  logic       take_esc_i,
    input  logic       take_opc_i,
    input  byte_kind_e kind_i,
    input  rep_e       rep_sel_i,
    input  seg_e       seg_sel_i,
    input  logic [7:0] code_i,
    input  logic       mode32_i,
    output rec_t       rec_o
);

    rec_t rec_q;
    logic op_flip_q;
    logic ad_flip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q     <= REC_IDLE;
            op_flip_q <= 1'b0;
            ad_flip_q <= 1'b0;
        end else if (clr_i) begin
            rec_q     <= REC_IDLE;
            op_flip_q <= 1'b0;
            ad_flip_q <= 1'b0;
        end else begin
            if (take_pfx_i) begin
                unique case (kind_i)
                    BK_OPSZ: op_flip_q <= 1'b1;
                    BK_ADSZ: ad_flip_q <= 1'b1;
                    BK_REP:  rec_q.rep <= rep_sel_i;
                    BK_SEG: begin
                        rec_q.seg <= seg_sel_i;
                        rec_q.ovr <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (take_esc_i) begin
                rec_q.esc <= 1'b1;
            end
            if (take_opc_i) begin
                rec_q.opcode <= code_i;
                rec_q.op32   <= mode32_i ^ op_flip_q;
                rec_q.ad32   <= mode32_i ^ ad_flip_q;
            end
        end
    end

    assign rec_o = rec_q;

endmodule

// File: rtl/opc_frontend.sv
module opc_frontend
    import opc_fe_pkg::*;
#(
    parameter  int MAX_LEN = 15,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode32_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    output logic             byte_ready_o,
    output logic             rec_valid_o,
    output logic [7:0]       rec_opcode_o,
    output logic             rec_escape_o,
    output logic             rec_op32_o,
    output logic             rec_ad32_o,
    output logic [1:0]       rec_rep_o,
    output logic [1:0]       rec_seg_o,
    output logic             rec_seg_ovr_o,
    output logic [LEN_W-1:0] rec_len_o,
    output logic             err_o
);

    fe_state_e  state_q, state_d;
    byte_kind_e kind;
    rep_e       rep_sel;
    seg_e       seg_sel;
    rec_t       rec;
    logic [LEN_W-1:0] count;
    logic       last_slot;
    logic       accept;
    logic       is_pfx;
    logic       need_more;
    logic       take_pfx, take_esc, take_opc;
    logic       clr_ctx;

    opc_fe_classify u_cls (
        .code_i    (byte_data_i),
        .kind_o    (kind),
        .rep_sel_o (rep_sel),
        .seg_sel_o (seg_sel)
    );

    opc_fe_lencnt #(
        .MAX_LEN (MAX_LEN),
        .CW      (LEN_W)
    ) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (accept),
        .clr_i       (clr_ctx),
        .count_o     (count),
        .last_slot_o (last_slot)
    );

    opc_fe_ctx u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_ctx),
        .take_pfx_i (take_pfx),
        .take_esc_i (take_esc),
        .take_opc_i (take_opc),
        .kind_i     (kind),
        .rep_sel_i  (rep_sel),
        .seg_sel_i  (seg_sel),
        .code_i     (byte_data_i),
        .mode32_i   (mode32_i),
        .rec_o      (rec)
    );

    assign accept    = byte_valid_i && byte_ready_o;
    assign is_pfx    = (kind == BK_OPSZ) || (kind == BK_ADSZ) ||
                       (kind == BK_REP)  || (kind == BK_SEG);
    assign need_more = is_pfx || (kind == BK_ESC);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PREFIX;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PREFIX: begin
                if (accept) begin
                    if (need_more && last_slot) begin
                        state_d = ST_FAULT;         // T_OVF
                    end else if (kind == BK_ESC) begin
                        state_d = ST_ESCAPE;        // T_ESC
                    end else if (!is_pfx) begin
                        state_d = ST_EMIT;          // T_OPC
                    end                             // T_PFX: stay
                end
            end
            ST_ESCAPE: begin
                if (accept) begin
                    state_d = ST_EMIT;              // T_ESC2
                end
            end
            ST_EMIT:  state_d = ST_PREFIX;          // T_EMIT
            ST_FAULT: state_d = ST_PREFIX;          // T_DROP
            default:  state_d = ST_PREFIX;
        endcase
    end

    // Outputs and per-state controls
    always_comb begin
        byte_ready_o = 1'b0;
        rec_valid_o  = 1'b0;
        err_o        = 1'b0;
        clr_ctx      = 1'b0;
        take_pfx     = 1'b0;
        take_esc     = 1'b0;
        take_opc     = 1'b0;
        unique case (state_q)
            ST_PREFIX: begin
                byte_ready_o = 1'b1;
                take_pfx     = accept && is_pfx && !last_slot;
                take_esc     = accept && (kind == BK_ESC) && !last_slot;
                take_opc     = accept && !need_more;
            end
            ST_ESCAPE: begin
                byte_ready_o = 1'b1;
                take_opc     = accept;
            end
            ST_EMIT: begin
                rec_valid_o = 1'b1;
                clr_ctx     = 1'b1;
            end
            ST_FAULT: begin
                err_o   = 1'b1;
                clr_ctx = 1'b1;
            end
            default: ;
        endcase
    end

    assign rec_opcode_o  = rec.opcode;
    assign rec_escape_o  = rec.esc;
    assign rec_op32_o    = rec.op32;
    assign rec_ad32_o    = rec.ad32;
    assign rec_rep_o     = rec.rep;
    assign rec_seg_o     = rec.seg;
    assign rec_seg_ovr_o = rec.ovr;
    assign rec_len_o     = count;

endmodule

// File: rtl/opc_frontend_chk.sv
module opc_frontend_chk #(
    parameter int MAX_LEN = 15,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid_i,
    input logic             byte_ready_o,
    input logic             rec_valid_o,
    input logic             rec_escape_o,
    input logic [1:0]       rec_rep_o,
    input logic [1:0]       rec_seg_o,
    input logic             rec_seg_ovr_o,
    input logic [LEN_W-1:0] rec_len_o,
    input logic             err_o
);

    p_rec_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |=> !rec_valid_o);

    p_rec_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> !byte_ready_o);

    p_rec_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> $past(byte_valid_i && byte_ready_o));

    p_rec_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_len_o >= 1) && (rec_len_o <= LEN_W'(MAX_LEN)));

    p_esc_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && rec_escape_o) |-> (rec_len_o >= 2));

    p_rep_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_rep_o != 2'd3));

    p_seg_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_seg_ovr_o) |-> (rec_seg_o == 2'd3));

    p_err_no_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rec_valid_o);

    p_err_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rec_len_o == LEN_W'(MAX_LEN)));

    p_err_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

bind opc_frontend opc_frontend_chk #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid_i  (byte_valid_i),
    .byte_ready_o  (byte_ready_o),
    .rec_valid_o   (rec_valid_o),
    .rec_escape_o  (rec_escape_o),
    .rec_rep_o     (rec_rep_o),
    .rec_seg_o     (rec_seg_o),
    .rec_seg_ovr_o (rec_seg_ovr_o),
    .rec_len_o     (rec_len_o),
    .err_o         (err_o)
);

// File: tb/opc_frontend_tb.sv
`timescale 1ns/1ps
module opc_frontend_tb;

    localparam int MAX_LEN = 15;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int NV      = 13;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic            mode;
        logic [3:0]      n;
        logic [7:0][7:0] seq;    // seq[0] is sent first
        logic [7:0]      op;
        logic            esc;
        logic            o32;
        logic            a32;
        logic [1:0]      rep;
        logic [1:0]      seg;
        logic            ovr;
        logic [3:0]      len;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd1, 64'h90,         8'h90, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd1},
        '{1'b0, 4'd2, 64'hB866,       8'hB8, 1'b0, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2},
        '{1'b1, 4'd2, 64'hB866,       8'hB8, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 4'd2},
        '{1'b0, 4'd4, 64'h8B666667,   8'h8B, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 1'b0, 4'd4},
        '{1'b0, 4'd3, 64'hA6F3F2,     8'hA6, 1'b0, 1'b0, 1'b0, 2'd2, 2'd3, 1'b0, 4'd3},
        '{1'b0, 4'd3, 64'hAEF2F3,     8'hAE, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0, 4'd3},
        '{1'b0, 4'd4, 64'h8B362E26,   8'h8B, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1, 4'd4},
        '{1'b0, 4'd2, 64'h8A2E,       8'h8A, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1, 4'd2},
        '{1'b0, 4'd2, 64'h840F,       8'h84, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2},
        '{1'b1, 4'd5, 64'hAF0FF33E67, 8'hAF, 1'b1, 1'b1, 1'b0, 2'd2, 2'd3, 1'b1, 4'd5},
        '{1'b1, 4'd2, 64'hA426,       8'hA4, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 4'd2},
        '{1'b0, 4'd2, 64'h0F0F,       8'h0F, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2},
        '{1'b0, 4'd2, 64'h660F,       8'h66, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2}
    };

    localparam string TAGS [NV] = '{
        "R6 plain opcode", "R2 opsize 16->32", "R2 opsize 32->16 R10",
        "R3 repeated size prefixes", "R4 repe wins", "R4 repne wins",
        "R5 last segment wins", "R5 CS override", "R7 escape",
        "R8 mixed prefixes", "R5 ES override 32-bit", "R7 escape then 0F",
        "R7 prefix code after escape"
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode32_i = 1'b0;
    logic             byte_valid_i = 1'b0;
    logic [7:0]       byte_data_i = 8'h00;
    logic             byte_ready_o;
    logic             rec_valid_o;
    logic [7:0]       rec_opcode_o;
    logic             rec_escape_o;
    logic             rec_op32_o;
    logic             rec_ad32_o;
    logic [1:0]       rec_rep_o;
    logic [1:0]       rec_seg_o;
    logic             rec_seg_ovr_o;
    logic [LEN_W-1:0] rec_len_o;
    logic             err_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    opc_frontend #(.MAX_LEN(MAX_LEN)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode32_i      (mode32_i),
        .byte_valid_i  (byte_valid_i),
        .byte_data_i   (byte_data_i),
        .byte_ready_o  (byte_ready_o),
        .rec_valid_o   (rec_valid_o),
        .rec_opcode_o  (rec_opcode_o),
        .rec_escape_o  (rec_escape_o),
        .rec_op32_o    (rec_op32_o),
        .rec_ad32_o    (rec_ad32_o),
        .rec_rep_o     (rec_rep_o),
        .rec_seg_o     (rec_seg_o),
        .rec_seg_ovr_o (rec_seg_ovr_o),
        .rec_len_o     (rec_len_o),
        .err_o         (err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the byte is taken.
    task automatic send_byte(input logic [7:0] b);
        while (!byte_ready_o) @(negedge clk);
        byte_valid_i = 1'b1;
        byte_data_i  = b;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    function automatic logic [31:0] rec_word();
        return {12'd0, rec_opcode_o, rec_escape_o, rec_op32_o, rec_ad32_o,
                rec_rep_o, rec_seg_o, rec_seg_ovr_o, 4'(rec_len_o)};
    endfunction

    function automatic logic [31:0] exp_word(input vec_t v);
        return {12'd0, v.op, v.esc, v.o32, v.a32, v.rep, v.seg, v.ovr, v.len};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog: cycles=%0d expected<=%0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready after reset", 32'(byte_ready_o), 32'd1);
        chk("R1 no record after reset", 32'(rec_valid_o), 32'd0);
        chk("R1 no error after reset", 32'(err_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            mode32_i = VECS[i].mode;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                send_byte(VECS[i].seq[k]);
            end
            chk({TAGS[i], " valid"}, 32'(rec_valid_o), 32'd1);
            chk({TAGS[i], " R6 ready low"}, 32'(byte_ready_o), 32'd0);
            chk({TAGS[i], " record"}, rec_word(), exp_word(VECS[i]));
        end

        // R6: record lasts one cycle, then input reopens
        @(negedge clk);
        chk("R6 record drops after one cycle", 32'(rec_valid_o), 32'd0);
        chk("R6 ready returns", 32'(byte_ready_o), 32'd1);

        // R8/R9 boundary: 14 prefixes + opcode = 15 bytes, accepted
        mode32_i = 1'b0;
        for (int k = 0; k < 13; k++) send_byte(8'h3E);
        send_byte(8'h66);
        send_byte(8'h90);
        chk("R9 full-length instruction accepted", 32'(rec_valid_o), 32'd1);
        chk("R8 full-length record",
            rec_word(), {12'd0, 8'h90, 1'b0, 1'b1, 1'b0, 2'd0, 2'd3, 1'b1, 4'd15});

        // R9: 15 prefixes overflow
        for (int k = 0; k < 15; k++) send_byte(8'hF3);
        chk("R9 error on prefix overflow", 32'(err_o), 32'd1);
        chk("R9 no record on overflow", 32'(rec_valid_o), 32'd0);
        chk("R9 ready low in error cycle", 32'(byte_ready_o), 32'd0);
        // R10: next instruction starts clean
        send_byte(8'h90);
        chk("R10 clean after error",
            rec_word(), {12'd0, 8'h90, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd1});

        // R9: escape in the last slot overflows too
        for (int k = 0; k < 14; k++) send_byte(8'h67);
        send_byte(8'h0F);
        chk("R9 error on escape in last slot", 32'(err_o), 32'd1);
        send_byte(8'h0F);
        send_byte(8'h31);
        chk("R10 escape after dropped instruction",
            rec_word(), {12'd0, 8'h31, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2});

        @(negedge clk);
        chk("R9 error clears", 32'(err_o), 32'd0);
        finish_run();
    end

endmodule